// File: doc/BRIEF.md
# Daisy-Chain Bus Arbitration Node

This block sits beside one device on a shared bus. The bus grant travels along a daisy chain, and a central priority arbiter collects the request lines. When the device needs the bus, the node raises a request toward the arbiter. A grant that reaches the node is either claimed or passed down the chain. The node claims it when a request of its own is already pending. Otherwise it forwards the grant to the next device.

After a claim, the node acknowledges the grant and drops its request. It then waits for the busy line driven by the current master to fall, and only then drives busy itself. While it owns the bus, it runs one master/slave strobe exchange. First it raises the master strobe and holds it until the slave answers. Next it drops the strobe and waits for the slave answer to clear. Last it releases busy and goes idle.

A node that is forwarding the grant goes back to idle only when the incoming grant goes low. This means a node further down the chain cannot drop a grant that is still present upstream.

Top module: `bus_arb_node`

## Requirements
- R1: While reset is asserted and on the first cycle after it, all five outputs (bus_req_o, grant_out_o, ack_o, busy_out_o, master_sync_o) are low.
- R2: In idle, a high dev_req_i with grant_in_i low makes bus_req_o high from the next cycle. It stays high until a grant is sampled.
- R3: When grant_in_i is sampled high while bus_req_o is high, ack_o rises and bus_req_o falls in the next cycle.
- R4: When grant_in_i is sampled high in idle, grant_out_o rises in the next cycle and stays high while grant_in_i stays high. This also holds if dev_req_i rises in the same cycle, because no request is pending yet.
- R5: Forwarding ends only when grant_in_i is sampled low, and grant_out_o is low in the next cycle. A dev_req_i raised during forwarding produces no bus_req_o until forwarding has ended.
- R6: After ack_o is high, busy_out_o stays low until a falling edge of busy_in_i is seen. A falling edge is a high sample followed by a low sample on consecutive clocks. In the cycle after the low sample, busy_out_o and master_sync_o are high and ack_o is low. A busy_in_i that is already low does not count as a falling edge.
- R7: master_sync_o stays high until slave_sync_i is sampled high. In the next cycle master_sync_o is low and busy_out_o is still high.
- R8: With master_sync_o low, busy_out_o stays high while slave_sync_i is high. busy_out_o goes low in the cycle after slave_sync_i is sampled low.
- R9: grant_out_o is never high in the same cycle as bus_req_o, ack_o or busy_out_o.
- R10: A grant_in_i that arrives while the node waits for busy or owns the bus is not forwarded: grant_out_o stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock; all inputs are synchronous to it |
| rst_n | input | 1 | Asynchronous active-low reset |
| dev_req_i | input | 1 | Device wants a bus transaction |
| grant_in_i | input | 1 | Grant arriving from the upstream end of the chain |
| busy_in_i | input | 1 | Bus busy line as driven by the present master |
| slave_sync_i | input | 1 | Slave-side transfer strobe |
| bus_req_o | output | 1 | Request to the central priority arbiter |
| grant_out_o | output | 1 | Grant passed to the downstream device |
| ack_o | output | 1 | Grant accepted by this node |
| busy_out_o | output | 1 | Busy driven while this node is master |
| master_sync_o | output | 1 | Master-side transfer strobe |

## Verification
The bench checks that the node waits for a real falling edge of busy. If busy is already low when the grant is taken, a node that treated a low level as a release would start driving busy at once, and the bench would see that. The bench raises the device request and the grant in the same cycle, and raises the request again during forwarding. A node that mixed these up would claim a grant it never requested, or would leave the chain cut off. The bench also drops the grant while the node is forwarding and sends a second grant while the node owns the bus. A node that left forwarding on the wrong condition, or that forwarded a grant while mastering, would show a wrong grant_out_o. Each handshake phase is held for more than one cycle, so an early release of the strobe or of busy is caught.

// File: rtl/arb_node_pkg.sv
package arb_node_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_REQ   = 3'd1,
        ST_FWD   = 3'd2,
        ST_WAIT  = 3'd3,
        ST_MDRV  = 3'd4,
        ST_MREL  = 3'd5
    } node_state_e;

    typedef struct packed {
        node_state_e state;
    } fsm_regs_t;

    typedef struct packed {
        logic bus_req;
        logic grant_out;
        logic ack;
        logic busy_out;
        logic master_sync;
    } node_out_t;

endpackage

// File: rtl/busy_edge_det.sv
module busy_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic busy_i,
    output logic fall_o
);

    logic busy_d, busy_q;

    always_comb begin
        busy_d = busy_i;
        fall_o = busy_q & ~busy_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) busy_q <= 1'b0;
        else        busy_q <= busy_d;
    end

endmodule

// File: rtl/arb_node_fsm.sv
module arb_node_fsm
    import arb_node_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      dev_req_i,
    input  logic      grant_in_i,
    input  logic      busy_fall_i,
    input  logic      slave_sync_i,
    output node_out_t out_o
);

    fsm_regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        unique case (regs_q.state)
            ST_IDLE: begin
                if (grant_in_i)     regs_d.state = ST_FWD;
                else if (dev_req_i) regs_d.state = ST_REQ;
            end
            ST_REQ:  if (grant_in_i)    regs_d.state = ST_WAIT;
            ST_FWD:  if (!grant_in_i)   regs_d.state = ST_IDLE;
            ST_WAIT: if (busy_fall_i)   regs_d.state = ST_MDRV;
            ST_MDRV: if (slave_sync_i)  regs_d.state = ST_MREL;
            ST_MREL: if (!slave_sync_i) regs_d.state = ST_IDLE;
            default: regs_d.state = ST_IDLE;
        endcase
    end

    always_comb begin
        out_o             = '0;
        out_o.bus_req     = (regs_q.state == ST_REQ);
        out_o.grant_out   = (regs_q.state == ST_FWD);
        out_o.ack         = (regs_q.state == ST_WAIT);
        out_o.busy_out    = (regs_q.state == ST_MDRV) || (regs_q.state == ST_MREL);
        out_o.master_sync = (regs_q.state == ST_MDRV);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '{state: ST_IDLE};
        else        regs_q <= regs_d;
    end

    AST_GRANT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        out_o.grant_out |-> !(out_o.bus_req || out_o.ack || out_o.busy_out)); // R9
    AST_REQ_TO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (out_o.bus_req && grant_in_i) |=> (out_o.ack && !out_o.bus_req)); // R3
    AST_FWD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_o.grant_out && grant_in_i) |=> out_o.grant_out); // R4
    AST_FWD_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (out_o.grant_out && !grant_in_i) |=> !out_o.grant_out); // R5
    AST_NO_EARLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (out_o.ack && !busy_fall_i) |=> (out_o.ack && !out_o.busy_out)); // R6
    AST_TAKE_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        (out_o.ack && busy_fall_i) |=> (out_o.busy_out && out_o.master_sync && !out_o.ack)); // R6
    AST_MSYNC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_o.master_sync && !slave_sync_i) |=> out_o.master_sync); // R7
    AST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_o.busy_out && !out_o.master_sync && !slave_sync_i) |=> !out_o.busy_out); // R8
    AST_NO_FWD_OWNED: assert property (@(posedge clk) disable iff (!rst_n)
        (out_o.ack || out_o.busy_out) |=> !out_o.grant_out); // R10

endmodule

// File: rtl/bus_arb_node.sv
module bus_arb_node
    import arb_node_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic dev_req_i,
    input  logic grant_in_i,
    input  logic busy_in_i,
    input  logic slave_sync_i,
    output logic bus_req_o,
    output logic grant_out_o,
    output logic ack_o,
    output logic busy_out_o,
    output logic master_sync_o
);

    logic      busy_fall;
    node_out_t outs;

    busy_edge_det u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .busy_i (busy_in_i),
        .fall_o (busy_fall)
    );

    arb_node_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .dev_req_i    (dev_req_i),
        .grant_in_i   (grant_in_i),
        .busy_fall_i  (busy_fall),
        .slave_sync_i (slave_sync_i),
        .out_o        (outs)
    );

    assign bus_req_o     = outs.bus_req;
    assign grant_out_o   = outs.grant_out;
    assign ack_o         = outs.ack;
    assign busy_out_o    = outs.busy_out;
    assign master_sync_o = outs.master_sync;

endmodule

// File: tb/sim_bus_arb_node.sv
`timescale 1ns/1ps
module sim_bus_arb_node;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic dev_req = 1'b0, grant_in = 1'b0, busy_in = 1'b0, slave_sync = 1'b0;
    logic bus_req, grant_out, ack, busy_out, msync;

    int n_checks = 0;
    int n_fail = 0;
    logic [4:0] exp_q[$];
    string      tag_q[$];

    always #4 clk = ~clk;

    bus_arb_node u0 (
        .clk(clk), .rst_n(rst_n), .dev_req_i(dev_req), .grant_in_i(grant_in),
        .busy_in_i(busy_in), .slave_sync_i(slave_sync), .bus_req_o(bus_req),
        .grant_out_o(grant_out), .ack_o(ack), .busy_out_o(busy_out),
        .master_sync_o(msync)
    );

    function automatic logic [4:0] outs();
        return {bus_req, grant_out, ack, busy_out, msync};
    endfunction

    task automatic check(input logic [4:0] got, input logic [4:0] exp, input string tag);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: outputs {req,gout,ack,busy,msync} = %b, expected %b", tag, got, exp);
        end
    endtask

    // Driver: drive inputs at the falling edge, queue the outputs expected after the next rising edge
    task automatic step(input logic dv, input logic gi, input logic bi, input logic si,
                        input logic [4:0] e, input string tag);
        @(negedge clk);
        dev_req = dv; grant_in = gi; busy_in = bi; slave_sync = si;
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    // Monitor: compare just after each rising edge
    always begin
        @(posedge clk);
        #2;
        if (exp_q.size() > 0) check(outs(), exp_q.pop_front(), tag_q.pop_front());
    end

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: run hung, actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        check(outs(), 5'b00000, "R1 in reset");
        rst_n = 1'b1;
        @(posedge clk); #2;
        check(outs(), 5'b00000, "R1 after reset");

        // Request, claim, wait for busy release, master handshake
        step(1,0,1,0, 5'b10000, "R2 request raised");
        step(1,0,1,0, 5'b10000, "R2 request held");
        step(1,1,1,0, 5'b00100, "R3 grant claimed");
        step(0,0,1,0, 5'b00100, "R6 busy still high");
        step(0,1,1,0, 5'b00100, "R10 grant not forwarded while waiting");
        step(0,0,0,0, 5'b00011, "R6 falling edge takes bus");
        step(0,0,0,0, 5'b00011, "R7 strobe held");
        step(0,1,0,0, 5'b00011, "R10 grant not forwarded while master");
        step(0,0,0,1, 5'b00010, "R7 strobe dropped");
        step(0,0,0,1, 5'b00010, "R8 busy held while slave high");
        step(0,0,0,0, 5'b00000, "R8 busy released");

        // Forwarding
        step(0,1,0,0, 5'b01000, "R4 grant forwarded");
        step(1,1,0,0, 5'b01000, "R5 request during forward ignored");
        step(1,0,0,0, 5'b00000, "R5 forward exits on grant low");
        step(1,0,0,0, 5'b10000, "R2 request after forward");
        step(1,1,0,0, 5'b00100, "R3 grant claimed");
        step(0,0,0,0, 5'b00100, "R6 low busy is not an edge");
        step(0,0,1,0, 5'b00100, "R6 busy rises");
        step(0,0,0,0, 5'b00011, "R6 edge after rise");
        step(0,0,0,1, 5'b00010, "R7 strobe dropped");
        step(0,0,0,0, 5'b00000, "R8 busy released");

        // Request and grant in the same idle cycle: no pending request
        step(1,1,0,0, 5'b01000, "R4 simultaneous request forwards");
        step(0,0,0,0, 5'b00000, "R5 forward exits");
        step(0,0,0,0, 5'b00000, "R9 idle quiet");

        repeat (3) @(posedge clk);
        #3;
        finish_run();
    end

endmodule